// File: doc/BRIEF.md
# Front-End Fast-Command Receiver with Per-Command Delay

This block sits in a detector front-end and recovers the 24-bit fast-control word that the timing system sends once per bunch crossing. The word travels over twelve serial lanes, two bits per lane per bunch period. The sampling clock runs at twice the bunch rate. In the half-period that starts on the rising bunch-clock edge, each lane carries an odd-numbered bit of the word. In the following half-period the same lane carries the even-numbered bit just below it. The block pairs the two halves back into one word and splits the word into a 12-bit crossing number, a 4-bit calibration code and eight single-bit commands.

The upstream link cannot delay individual lines. Each command therefore passes through its own local pipeline whose length can be set from 0 to 31 words, so that it reaches the front-end logic in step with the crossing it targets. Words are sent well ahead of their crossing, nominally sixteen bunch periods early plus transport. The crossing number and calibration code share one further pipeline with its own delay setting. All pipelines advance once per received word, and every output holds its value for a whole bunch period.

The block runs on the 2x sampling clock. A phase input marks the half that carries the odd bits.

Top module: `tfcCmdReceiver`

## Requirements
- R1: While synchronous reset is high, and after it is released until the first word has been delivered, every command output, `bxidOut` and `calibOut` read zero.
- R2: Lane k carries word bit 2k+1 in the sample where `firstHalf` is 1, and word bit 2k in the sample that immediately follows with `firstHalf` 0.
- R3: `bxidOut` carries word bits 23..12 and `calibOut` carries word bits 8..5, both taken from the tag pipeline.
- R4: `cmdStrobe` index 7 carries word bit 11 (synch), index 6 carries bit 10 (full readout), index 5 carries bit 9 (header only), index 4 carries bit 4 (crossing-counter reset), index 3 carries bit 3 (front-end reset), index 2 carries bit 2 (crossing veto), index 1 carries bit 1 (snapshot) and index 0 carries bit 0 (spare).
- R5: With a channel delay of D (0..31), after the n-th word is delivered the channel shows the field of word n-D. It shows zero when n-D is below zero.
- R6: Outputs update exactly on the clock edge two sampling cycles after the even-half sample. They then hold until the next delivered word.
- R7: A sample with `firstHalf` 0 that does not directly follow a sample with `firstHalf` 1 is ignored. It neither updates nor shifts any output or pipeline.
- R8: The nine channels are independent. Channel c of `delayCfg` uses bits [5c+4:5c]; channels 0..7 follow the `cmdStrobe` indices and channel 8 is the tag pipeline.
- R9: A reset asserted mid-stream clears every pipeline, so the words that follow see zero history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Lane sampling clock, twice the bunch rate |
| rst | input | 1 | Synchronous reset, active high |
| firstHalf | input | 1 | High in the sample holding the odd-numbered bits |
| laneBits | input | 12 | One sampled bit per serial lane |
| delayCfg | input | 45 | Nine 5-bit delay settings, one per channel |
| cmdStrobe | output | 8 | Delayed single-bit commands |
| bxidOut | output | 12 | Delayed crossing number |
| calibOut | output | 4 | Delayed calibration code |

## Verification
The bench sweeps many sets of delay settings, including 0, 31 and a distinct value for every channel. It checks each channel against a history of sent words in every bunch period. A design that swapped the odd and even halves, or misplaced a field, fails at delay 0 with all-ones and hashed words. A design that was off by one in its tap selection fails at the extreme delays. Gaps filled with junk even-half samples expose a design that assembles a word without a first half, because the later outputs shift out of line. A reset in the middle of the stream exposes pipelines that keep old words.

// File: rtl/tfcRxPkg.sv
package tfcRxPkg;
  localparam int WORD_W  = 24;
  localparam int LANES   = WORD_W / 2;
  localparam int NCMD    = 8;
  localparam int BXID_W  = 12;
  localparam int BXID_LSB = WORD_W - BXID_W;
  localparam int CAL_W   = 4;
  localparam int CAL_LSB = 5;
  localparam int TAG_W   = BXID_W + CAL_W;
  localparam int NCHAN   = NCMD + 1;

  typedef struct packed {
    logic captureOdd;
    logic assemble;
    logic advance;
  } rxStrobes_t;

  // word bit carried by each command output index
  function automatic int cmdBitPos(input int idx);
    case (idx)
      7: return 11;
      6: return 10;
      5: return 9;
      default: return idx;
    endcase
  endfunction
endpackage

// File: rtl/tfcRxCtrl.sv
module tfcRxCtrl
  import tfcRxPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       firstHalf,
  output rxStrobes_t strobes
);
  logic haveOdd;
  logic advanceQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      haveOdd  <= 1'b0;
      advanceQ <= 1'b0;
    end else begin
      haveOdd  <= firstHalf;
      advanceQ <= !firstHalf && haveOdd;
    end
  end

  always_comb begin
    strobes.captureOdd = firstHalf;
    strobes.assemble   = !firstHalf && haveOdd;
    strobes.advance    = advanceQ;
  end
endmodule

// File: rtl/tfcDelayLine.sv
module tfcDelayLine #(
  parameter int W     = 1,
  parameter int DLY_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shiftEn,
  input  logic [DLY_W-1:0] delaySel,
  input  logic [W-1:0]     dIn,
  output logic [W-1:0]     dOut
);
  localparam int DEPTH = (1 << DLY_W) - 1;

  logic [W-1:0] stage [DEPTH];
  logic [W-1:0] tapVal;

  always_comb begin
    tapVal = dIn;
    for (int i = 0; i < DEPTH; i++) begin
      if (delaySel == DLY_W'(i + 1)) tapVal = stage[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) stage[i] <= '0;
      dOut <= '0;
    end else if (shiftEn) begin
      stage[0] <= dIn;
      for (int i = 1; i < DEPTH; i++) stage[i] <= stage[i-1];
      dOut <= tapVal;
    end
  end
endmodule

// File: rtl/tfcRxDatapath.sv
module tfcRxDatapath
  import tfcRxPkg::*;
#(
  parameter int DLY_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  rxStrobes_t             strobes,
  input  logic [LANES-1:0]       laneBits,
  input  logic [NCHAN*DLY_W-1:0] delayCfg,
  output logic [NCMD-1:0]        cmdStrobe,
  output logic [BXID_W-1:0]      bxidOut,
  output logic [CAL_W-1:0]       calibOut
);
  logic [LANES-1:0]  oddHold;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] joined;
  logic [TAG_W-1:0]  tagOut;

  always_comb begin
    for (int k = 0; k < LANES; k++) begin
      joined[2*k+1] = oddHold[k];
      joined[2*k]   = laneBits[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      oddHold <= '0;
      word    <= '0;
    end else begin
      if (strobes.captureOdd) oddHold <= laneBits;
      if (strobes.assemble)   word    <= joined;
    end
  end

  for (genvar c = 0; c < NCMD; c++) begin : g_cmd
    localparam int POS = cmdBitPos(c);
    tfcDelayLine #(.W(1), .DLY_W(DLY_W)) line_i (
      .clk      (clk),
      .rst      (rst),
      .shiftEn  (strobes.advance),
      .delaySel (delayCfg[c*DLY_W +: DLY_W]),
      .dIn      (word[POS]),
      .dOut     (cmdStrobe[c])
    );
  end

  tfcDelayLine #(.W(TAG_W), .DLY_W(DLY_W)) tag_i (
    .clk      (clk),
    .rst      (rst),
    .shiftEn  (strobes.advance),
    .delaySel (delayCfg[NCMD*DLY_W +: DLY_W]),
    .dIn      ({word[WORD_W-1:BXID_LSB], word[CAL_LSB+CAL_W-1:CAL_LSB]}),
    .dOut     (tagOut)
  );

  assign bxidOut  = tagOut[TAG_W-1:CAL_W];
  assign calibOut = tagOut[CAL_W-1:0];
endmodule

// File: rtl/tfcCmdReceiver.sv
module tfcCmdReceiver
  import tfcRxPkg::*;
#(
  parameter int DLY_W = 5
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   firstHalf,
  input  logic [LANES-1:0]       laneBits,
  input  logic [NCHAN*DLY_W-1:0] delayCfg,
  output logic [NCMD-1:0]        cmdStrobe,
  output logic [BXID_W-1:0]      bxidOut,
  output logic [CAL_W-1:0]       calibOut
);
  rxStrobes_t strobes;

  tfcRxCtrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .firstHalf (firstHalf),
    .strobes   (strobes)
  );

  tfcRxDatapath #(.DLY_W(DLY_W)) dp_i (
    .clk       (clk),
    .rst       (rst),
    .strobes   (strobes),
    .laneBits  (laneBits),
    .delayCfg  (delayCfg),
    .cmdStrobe (cmdStrobe),
    .bxidOut   (bxidOut),
    .calibOut  (calibOut)
  );
endmodule

// File: rtl/tfcCmdReceiverChk.sv
module tfcCmdReceiverChk
  import tfcRxPkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              firstHalf,
  input logic              advance,
  input logic [NCMD-1:0]   cmdStrobe,
  input logic [BXID_W-1:0] bxidOut,
  input logic [CAL_W-1:0]  calibOut
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cmdStrobe == '0 && bxidOut == '0 && calibOut == '0));

  // R6
  hold_between_chk: assert property (@(posedge clk) disable iff (rst)
    !advance |=> $stable({cmdStrobe, bxidOut, calibOut}));

  // R6
  one_per_bunch_chk: assert property (@(posedge clk) disable iff (rst)
    advance |=> !advance);

  // R7
  odd_half_no_step_chk: assert property (@(posedge clk) disable iff (rst)
    firstHalf |=> !advance);

  // R7
  orphan_even_chk: assert property (@(posedge clk) disable iff (rst)
    (!firstHalf && !$past(firstHalf)) |=> !advance);
endmodule

bind tfcCmdReceiver tfcCmdReceiverChk chk_i (
  .clk       (clk),
  .rst       (rst),
  .firstHalf (firstHalf),
  .advance   (strobes.advance),
  .cmdStrobe (cmdStrobe),
  .bxidOut   (bxidOut),
  .calibOut  (calibOut)
);

// File: tb/tfcCmdReceiver_tb_top.sv
`timescale 1ns/1ps
module tfcCmdReceiver_tb_top;
  localparam int NW = 45;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        firstHalf = 1'b0;
  logic [11:0] laneBits = '0;
  logic [44:0] delayCfg = '0;
  logic [7:0]  cmdStrobe;
  logic [11:0] bxidOut;
  logic [3:0]  calibOut;

  int checks = 0;
  int failures = 0;
  int dly [9];
  logic [23:0] hist [64];

  always #2.5 clk = ~clk;

  tfcCmdReceiver dut_i (
    .clk(clk), .rst(rst), .firstHalf(firstHalf), .laneBits(laneBits),
    .delayCfg(delayCfg), .cmdStrobe(cmdStrobe), .bxidOut(bxidOut), .calibOut(calibOut)
  );

  function automatic logic [23:0] genWord(input int n, input int cfg);
    logic [31:0] x;
    if (n % 7 == 3) return 24'hFFFFFF;
    x = 32'(n) * 32'h9E3779B1 ^ 32'(cfg + 1) * 32'h85EBCA6B;
    x = x ^ (x >> 13);
    return x[23:0];
  endfunction

  // R4: output index -> word bit
  function automatic int posOf(input int c);
    if (c == 7) return 11;
    if (c == 6) return 10;
    if (c == 5) return 9;
    return c;
  endfunction

  task automatic applyDelays();
    for (int c = 0; c < 9; c++) delayCfg[c*5 +: 5] = dly[c][4:0];
  endtask

  task automatic checkOutputs(input int k, input string req);
    for (int c = 0; c < 9; c++) begin
      logic [23:0] src;
      src = (k - dly[c] >= 0) ? hist[k - dly[c]] : 24'h0;
      checks++;
      if (c < 8) begin
        if (cmdStrobe[c] !== src[posOf(c)]) begin
          failures++;
          $display("FAIL %s R4 R5 R8 cmd%0d word%0d dly%0d: got %b expected %b",
                   req, c, k, dly[c], cmdStrobe[c], src[posOf(c)]);
        end
      end else begin
        if ({bxidOut, calibOut} !== {src[23:12], src[8:5]}) begin
          failures++;
          $display("FAIL %s R3 R5 tag word%0d dly%0d: got %h expected %h",
                   req, k, dly[c], {bxidOut, calibOut}, {src[23:12], src[8:5]});
        end
      end
    end
  endtask

  task automatic checkZero(input string req);
    checks++;
    if ({cmdStrobe, bxidOut, calibOut} !== '0) begin
      failures++;
      $display("FAIL %s outputs after reset: got %h expected 0", req,
               {cmdStrobe, bxidOut, calibOut});
    end
  endtask

  task automatic doReset(input string req);
    @(negedge clk);
    rst = 1'b1; firstHalf = 1'b1; laneBits = 12'hFFF;
    repeat (3) @(negedge clk);
    checkZero(req);
    rst = 1'b0; firstHalf = 1'b0; laneBits = 12'h0;
    @(negedge clk);
    checkZero(req);
  endtask

  // R2 lane order, R6 update edge, R7 junk gap
  task automatic runStream(input int cfg, input int gapAt);
    for (int n = 0; n < NW; n++) begin
      logic [23:0] w;
      w = genWord(n, cfg);
      hist[n] = w;
      @(negedge clk);
      if (n >= 2) checkOutputs((n - 1 == gapAt) ? n - 1 : n - 2, "R6");
      firstHalf = 1'b1;
      for (int k = 0; k < 12; k++) laneBits[k] = w[2*k+1];
      @(negedge clk);
      if (n > 0) checkOutputs(n - 1, "R2");
      firstHalf = 1'b0;
      for (int k = 0; k < 12; k++) laneBits[k] = w[2*k];
      if (n == gapAt) begin
        for (int g = 0; g < 5; g++) begin
          @(negedge clk);
          if (g > 0) checkOutputs(n, "R7");
          firstHalf = 1'b0;
          laneBits = 12'(32'hA5C * (g + 3));
        end
      end
    end
    @(negedge clk);
    firstHalf = 1'b0; laneBits = '0;
    @(negedge clk);
    checkOutputs(NW - 1, "R5");
  endtask

  initial begin : watchdog
    #(200000 * 5);
    failures++;
    $display("FAIL watchdog expired: got timeout expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    for (int c = 0; c < 9; c++) dly[c] = 0;
    applyDelays();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    checkZero("R1");
    // delay 0 on every channel: direct lane and field mapping
    runStream(0, 10);
    for (int cfg = 1; cfg < 9; cfg++) begin
      for (int c = 0; c < 9; c++) begin
        if (cfg == 1) dly[c] = 31;
        else if (cfg == 2) dly[c] = c * 3 + 1;
        else if (cfg == 3) dly[c] = 31 - c * 3;
        else dly[c] = (cfg * 5 + c * 7) % 32;
      end
      applyDelays();
      // R9: reset between streams must clear all pipelines
      doReset("R9");
      runStream(cfg, 5 + cfg * 3);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule